// File: doc/BRIEF.md
# HDLC FIFO Watermark Status Logic

This block turns the occupancy of an HDLC controller's transmit and receive word FIFOs into the status flags and interrupt requests a bus host polls or services. The transmit-available flag says how much data the host may write. The receive-available flag says how much it may read. In each direction a mode bit picks the grain of one word or a burst of four words. With a burst, the host moves four words after a single status read.

The block also reports the byte-valid mask of a frame's final partial word, so that the host knows how many bytes of that word to keep. It raises the two interrupt requests. The receive request is silenced while a DMA engine drains the receive FIFO. Every output is registered and follows its inputs with one cycle of latency.

Top module: `hdlc_fifo_watermark`

## Requirements
- R1: During reset and in the first cycle after it, tx_avail, rx_avail, rx_residue, tx_irq and rx_irq are all 0.
- R2: With tx_burst_mode = 0, tx_avail is 1 exactly when tx_count is at most DEPTH-1, that is, when at least one word of space is free.
- R3: With tx_burst_mode = 1, tx_avail is 1 exactly when DEPTH - tx_count is at least BURST (4 by default).
- R4: With rx_burst_mode = 0, rx_avail is 1 exactly when rx_count is at least 1.
- R5: With rx_burst_mode = 1, rx_avail is 1 exactly when rx_count is at least BURST.
- R6: rx_residue is the one-hot mask 1 << rx_last_bytes. Code 0 means one valid byte and sets bit 0; code 3 means four valid bytes and sets bit 3. It is shown only while rx_head_last = 1 and rx_count is at least 1. Otherwise it is 0.
- R7: With rx_burst_mode = 1, rx_residue is also forced to 0 while rx_count is at least BURST. In that case the final word is drained as part of a burst.
- R8: rx_irq equals rx_avail AND rx_irq_en AND NOT rx_dma_en. While DMA receive is enabled, the receive request never asserts.
- R9: tx_irq equals tx_avail AND tx_irq_en.
- R10: Each output reflects the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_count | input | CW (4) | Words currently held in the transmit FIFO, 0..DEPTH |
| rx_count | input | CW (4) | Words currently held in the receive FIFO, 0..DEPTH |
| rx_head_last | input | 1 | Word at the receive FIFO head is the last word of a frame |
| rx_last_bytes | input | 2 | Valid bytes in that last word minus one |
| tx_burst_mode | input | 1 | Transmit grain: 0 one word, 1 four words |
| rx_burst_mode | input | 1 | Receive grain: 0 one word, 1 four words |
| rx_dma_en | input | 1 | DMA receive active; masks the receive interrupt |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_avail | output | 1 | Transmit data-available flag |
| rx_avail | output | 1 | Receive data-available flag |
| rx_residue | output | 4 | One-hot byte-valid mask of the frame's final word |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that both occupancy counts never exceed DEPTH. A FIFO cannot hold more words than its depth, and the free-space subtraction would wrap if a count did. The random stimulus draws each count from 0..DEPTH only. It weights the draws toward the thresholds at 0, 1, DEPTH-BURST, BURST, DEPTH-1 and DEPTH. Mode, DMA, enable and frame-end inputs change freely from cycle to cycle, because the block places no ordering rule on them.

// File: rtl/hdlc_fifo_watermark.sv
module hdlc_fifo_watermark #(
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_head_last,
  input  logic [1:0]    rx_last_bytes,
  input  logic          tx_burst_mode,
  input  logic          rx_burst_mode,
  input  logic          rx_dma_en,
  input  logic          tx_irq_en,
  input  logic          rx_irq_en,
  output logic          tx_avail,
  output logic          rx_avail,
  output logic [3:0]    rx_residue,
  output logic          tx_irq,
  output logic          rx_irq
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] BURST_C = CW'(BURST);

  logic [CW-1:0] tx_free;
  logic [CW-1:0] tx_need, rx_need;
  logic          tx_ok, rx_ok, res_show;

  assign tx_free  = DEPTH_C - tx_count;
  assign tx_need  = tx_burst_mode ? BURST_C : CW'(1);
  assign rx_need  = rx_burst_mode ? BURST_C : CW'(1);
  assign tx_ok    = tx_free >= tx_need;
  assign rx_ok    = rx_count >= rx_need;
  assign res_show = rx_head_last && (rx_count != '0) &&
                    (!rx_burst_mode || (rx_count < BURST_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_avail   <= 1'b0;
      rx_avail   <= 1'b0;
      rx_residue <= 4'b0;
      tx_irq     <= 1'b0;
      rx_irq     <= 1'b0;
    end else begin
      tx_avail   <= tx_ok;
      rx_avail   <= rx_ok;
      rx_residue <= res_show ? (4'b0001 << rx_last_bytes) : 4'b0;
      tx_irq     <= tx_ok & tx_irq_en;
      rx_irq     <= rx_ok & rx_irq_en & ~rx_dma_en;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= DEPTH_C) && (rx_count <= DEPTH_C)); // R2
  AST_TX_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == DEPTH_C) |=> !tx_avail); // R2
  AST_RX_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> (!rx_avail && rx_residue == 4'b0)); // R4
  AST_RES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_residue)); // R6
  AST_BURST_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_burst_mode && rx_count >= BURST_C) |=> (rx_residue == 4'b0)); // R7
  AST_DMA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_en |=> !rx_irq); // R8
  AST_TXIRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_avail); // R9

endmodule

// File: tb/hdlc_fifo_watermark_tb.sv
module hdlc_fifo_watermark_tb_top;
  localparam int DEPTH = 8;
  localparam int BURST = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] tx_count = '0, rx_count = '0;
  logic rx_head_last = 0, tx_burst_mode = 0, rx_burst_mode = 0;
  logic rx_dma_en = 0, tx_irq_en = 0, rx_irq_en = 0;
  logic [1:0] rx_last_bytes = '0;
  logic tx_avail, rx_avail, tx_irq, rx_irq;
  logic [3:0] rx_residue;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hdlc_fifo_watermark #(.DEPTH(DEPTH), .BURST(BURST)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
    .rx_head_last(rx_head_last), .rx_last_bytes(rx_last_bytes),
    .tx_burst_mode(tx_burst_mode), .rx_burst_mode(rx_burst_mode),
    .rx_dma_en(rx_dma_en), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
    .tx_avail(tx_avail), .rx_avail(rx_avail), .rx_residue(rx_residue),
    .tx_irq(tx_irq), .rx_irq(rx_irq));

  function automatic bit exp_tx(int cnt, bit m4);
    return m4 ? (DEPTH - cnt >= BURST) : (cnt <= DEPTH - 1);
  endfunction
  function automatic bit exp_rx(int cnt, bit m4);
    return m4 ? (cnt >= BURST) : (cnt >= 1);
  endfunction
  function automatic logic [3:0] exp_res(int cnt, bit m4, bit last, int nb);
    if (!last || cnt == 0) return 4'b0;
    if (m4 && cnt >= BURST) return 4'b0;
    return 4'(1 << nb);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (tx=%0d rx=%0d)", req, act, exp, tx_count, rx_count);
    end
  endtask

  // drive at negedge, outputs registered at posedge, compare next negedge (R10)
  task automatic apply(int tc, int rc, bit tm, bit rm, bit last, int nb, bit dma, bit tie, bit rie);
    bit et, er;
    @(negedge clk);
    tx_count = CW'(tc); rx_count = CW'(rc); tx_burst_mode = tm; rx_burst_mode = rm;
    rx_head_last = last; rx_last_bytes = 2'(nb); rx_dma_en = dma; tx_irq_en = tie; rx_irq_en = rie;
    @(negedge clk);
    et = exp_tx(tc, tm);
    er = exp_rx(rc, rm);
    chk(tm ? "R3 tx_avail" : "R2 tx_avail", {3'b0, tx_avail}, {3'b0, et});
    chk(rm ? "R5 rx_avail" : "R4 rx_avail", {3'b0, rx_avail}, {3'b0, er});
    chk(rm ? "R7 rx_residue" : "R6 rx_residue", rx_residue, exp_res(rc, rm, last, nb));
    chk("R9 tx_irq", {3'b0, tx_irq}, {3'b0, et & tie});
    chk("R8 rx_irq", {3'b0, rx_irq}, {3'b0, er & rie & ~dma});
  endtask

  function automatic int pick_count();
    int r = $urandom_range(0, 9);
    case (r)
      0: return 0;
      1: return 1;
      2: return BURST;
      3: return DEPTH - BURST;
      4: return DEPTH - 1;
      5: return DEPTH;
      default: return $urandom_range(0, DEPTH);
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tx_irq_en = 1; rx_irq_en = 1; rx_head_last = 1; rx_count = 4'd3;
    #1;
    chk("R1 reset tx_avail", {3'b0, tx_avail}, 4'b0);
    chk("R1 reset rx_avail", {3'b0, rx_avail}, 4'b0);
    chk("R1 reset rx_residue", rx_residue, 4'b0);
    chk("R1 reset irqs", {2'b0, tx_irq, rx_irq}, 4'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after reset, before any edge with new inputs, outputs still 0
    #1;
    chk("R1 post-reset", {tx_avail, rx_avail, tx_irq, rx_irq}, 4'b0);

    // directed thresholds
    apply(DEPTH, 0, 0, 0, 0, 0, 0, 1, 1);          // R2 full, R4 empty
    apply(DEPTH - 1, 1, 0, 0, 1, 2, 0, 1, 1);      // R2/R4 edge, R6 three bytes
    apply(DEPTH - BURST, BURST, 1, 1, 0, 0, 0, 1, 1); // R3/R5 exactly at burst
    apply(DEPTH - BURST + 1, BURST - 1, 1, 1, 1, 3, 0, 1, 1); // R3/R5 just short, R7 residue shown
    apply(0, BURST, 1, 1, 1, 1, 0, 1, 1);          // R7 residue hidden in burst
    apply(0, DEPTH, 0, 0, 1, 0, 1, 1, 1);          // R8 DMA masks rx_irq
    apply(0, 0, 0, 0, 1, 3, 0, 0, 0);              // R6 empty hides residue, R9 disabled
    for (int nb = 0; nb < 4; nb++) apply(3, 2, 0, 0, 1, nb, 0, 1, 1); // R6 each code

    for (int i = 0; i < 3000; i++)
      apply(pick_count(), pick_count(), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule